// File: doc/BRIEF.md
# Gated-Clock Binary Down Counter

This block is a binary down counter that saves clock power by splitting its state into two groups. The least significant bit sits on its own gated clock, which runs on every cycle that does any work. The upper bits share a second gated clock. That clock is enabled only when the present state shows that one of those bits can actually change. Both clocks come from latch-based glitch-free gate cells.

The enable for the upper group is decoded from the present count. It has two terms. The decoded term is the top bit OR "all bits below the top are zero". The borrow term is "the ungated low bits are zero". The borrow term is needed because, on counts of 2, 4 and 6, bit 1 changes while bit 3 is clear. The upper clock therefore stays quiet on every counting step that leaves from 1, 3, 5 or 7. A synchronous reset and a parallel load each force both clocks on, so the state can be cleared or written whatever it holds. Reset has priority over load, and load has priority over counting.

The gated upper clock is also brought out at the ports. Neighbouring logic that follows the upper count can share the same gate.

Top module: `gated_down_counter`

## Requirements
- R1: When `rst` is high at a rising `clk` edge, `count` is 0 after that edge, whatever `cntEn`, `loadEn` and `loadVal` are.
- R2: When `loadEn` is high and `rst` is low at a rising edge, `count` equals `loadVal` after that edge, even if `cntEn` is also high.
- R3: When `cntEn` is high and `rst` and `loadEn` are low at a rising edge, `count` becomes `count - 1` modulo 16, so 0 is followed by 15.
- R4: When `rst`, `loadEn` and `cntEn` are all low, `count` keeps its value.
- R5: Bits 3..1 of `count` change only on rising edges of the shared gated clock `upClkOut`. While counting, that clock pulses exactly on the steps that leave from a count with bit 3 set or bit 0 clear. Over one uninterrupted 16-step wrap this gives 12 pulses.
- R6: No `upClkOut` pulse occurs on a counting step that leaves from 1, 3, 5 or 7. With `cntEn`, `loadEn` and `rst` all low, `upClkOut` never pulses.
- R7: A load or reset cycle forces one `upClkOut` pulse, including when the present count is 1, 3, 5 or 7.
- R8: `upClkOut` is low whenever `clk` is low, and its rising edges coincide with rising edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset to zero, highest priority |
| cntEn | input | 1 | Decrement enable |
| loadEn | input | 1 | Parallel load strobe, above counting |
| loadVal | input | 4 | Value written on a load |
| count | output | 4 | Present count |
| upClkOut | output | 1 | Gated clock of the upper three bits |

## Verification
The hardest case to reach from the ports is an upper-clock pulse that is missing or extra on one specific step. The count only goes wrong in that case if a borrow is lost, and an extra pulse never changes the count at all. The bench therefore counts rising edges of `upClkOut` itself. It compares the total against 12 per wrap over three uninterrupted wraps, and it flags any edge taken while the sampled count is odd and below 8. Directed steps then park the counter on 3 and 5 and apply a load, a reset or a hold. Each of these shows whether the forced enable, or its absence, produced the one expected pulse.

// File: rtl/gdc_pkg.sv
package gdc_pkg;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic clear;     // synchronous reset selected
    logic load;      // parallel load selected
    logic lowClkEn;  // enable for the always-active low group
    logic upClkEn;   // enable for the shared upper group
  } gdc_strobe_t;

endpackage

// File: rtl/gdc_clk_gate.sv
// Glitch-free clock gate: the enable is captured by a latch that is open
// while the clock is low, so it cannot move during the high phase.
module gdc_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);

  logic enLatched;

  always_latch begin
    if (!clk) enLatched <= en;
  end

  assign gclk = clk & enLatched;

endmodule

// File: rtl/gdc_ctrl.sv
// State decode for the two clock groups.
module gdc_ctrl
  import gdc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LOW_W = 1
) (
  input  logic             rst,
  input  logic             cntEn,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] count,
  output gdc_strobe_t      strb
);

  localparam int BELOW_W = CNT_W - 1;

  logic decodeTerm;  // top bit set, or everything below it zero
  logic borrowTerm;  // ungated low group is zero: decrement borrows upward
  logic upNeeded;

  always_comb begin
    decodeTerm = count[CNT_W-1] | (count[BELOW_W-1:0] == '0);
    borrowTerm = (count[LOW_W-1:0] == '0);
    upNeeded   = decodeTerm | borrowTerm;
  end

  always_comb begin
    strb.clear    = rst;
    strb.load     = loadEn & ~rst;
    strb.lowClkEn = rst | loadEn | cntEn;
    strb.upClkEn  = rst | loadEn | (cntEn & upNeeded);
  end

endmodule

// File: rtl/gdc_datapath.sv
// Two register groups, each on its own gated clock.
module gdc_datapath
  import gdc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LOW_W = 1
) (
  input  logic             clk,
  input  gdc_strobe_t      strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             upClk
);

  localparam int UP_W = CNT_W - LOW_W;

  logic             lowClk;
  logic [LOW_W-1:0] lowQ;
  logic [UP_W-1:0]  upQ;
  logic [CNT_W-1:0] nextVal;

  gdc_clk_gate i_lowGate (.clk(clk), .en(strb.lowClkEn), .gclk(lowClk));
  gdc_clk_gate i_upGate  (.clk(clk), .en(strb.upClkEn),  .gclk(upClk));

  always_comb begin
    if (strb.clear)     nextVal = '0;
    else if (strb.load) nextVal = loadVal;
    else                nextVal = count - 1'b1;
  end

  always_ff @(posedge lowClk) lowQ <= nextVal[LOW_W-1:0];
  always_ff @(posedge upClk)  upQ  <= nextVal[CNT_W-1:LOW_W];

  assign count = {upQ, lowQ};

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk)
    strb.clear |=> count == '0);  // R1

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (strb.clear)
    strb.load |=> count == $past(loadVal));  // R2

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.lowClkEn && !strb.load) |=> count == ($past(count) - 1'b1));  // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.lowClkEn |=> $stable(count));  // R4

  AST_BORROW_REACHES_UP: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.lowClkEn && !strb.load && count[LOW_W-1:0] == '0)
      |=> count[CNT_W-1:LOW_W] != $past(count[CNT_W-1:LOW_W]));  // R5

  AST_UP_QUIET_LOW_ODD: assert property (@(posedge upClk) disable iff (strb.clear)
    !strb.load |-> !(count[LOW_W-1:0] != '0 && !count[CNT_W-1]));  // R6

endmodule

// File: rtl/gated_down_counter.sv
module gated_down_counter
  import gdc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LOW_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cntEn,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             upClkOut
);

  gdc_strobe_t strb;

  gdc_ctrl #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_ctrl (
    .rst(rst), .cntEn(cntEn), .loadEn(loadEn), .count(count), .strb(strb)
  );

  gdc_datapath #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_dp (
    .clk(clk), .strb(strb), .loadVal(loadVal), .count(count), .upClk(upClkOut)
  );

  AST_FORCED_UP_CLOCK: assert property (@(posedge clk)
    (rst || loadEn) |-> strb.upClkEn);  // R7

endmodule

// File: tb/test_gated_down_counter.sv
`timescale 1ns/1ps
module test_gated_down_counter;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       cntEn = 1'b0;
  logic       loadEn = 1'b0;
  logic [3:0] loadVal = 4'd0;
  logic [3:0] count;
  logic       upClkOut;

  int checks = 0;
  int failures = 0;
  int upEdges = 0;
  int badEdges = 0;
  bit pureCount = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gated_down_counter i_gated_down_counter (
    .clk(clk), .rst(rst), .cntEn(cntEn), .loadEn(loadEn),
    .loadVal(loadVal), .count(count), .upClkOut(upClkOut)
  );

  // Upper-group clock monitor; count still holds the departing value here.
  always @(posedge upClkOut) begin
    upEdges++;
    if (pureCount && count[0] && !count[3]) badEdges++;
  end

  // Table vectors: [10] rst, [9] cntEn, [8] loadEn, [7:4] loadVal, [3:0] expected count
  localparam int NVEC = 15;
  localparam logic [10:0] VEC [0:NVEC-1] = '{
    {1'b1, 1'b0, 1'b0, 4'd0, 4'd0},    // reset
    {1'b0, 1'b1, 1'b0, 4'd0, 4'd15},   // wrap 0 -> 15
    {1'b0, 1'b1, 1'b0, 4'd0, 4'd14},
    {1'b0, 1'b0, 1'b0, 4'd7, 4'd14},   // hold
    {1'b0, 1'b0, 1'b1, 4'd9, 4'd9},    // load
    {1'b0, 1'b1, 1'b0, 4'd0, 4'd8},
    {1'b0, 1'b1, 1'b0, 4'd0, 4'd7},
    {1'b0, 1'b1, 1'b0, 4'd0, 4'd6},
    {1'b0, 1'b1, 1'b1, 4'd2, 4'd2},    // load beats count
    {1'b0, 1'b1, 1'b0, 4'd0, 4'd1},    // borrow from 2
    {1'b0, 1'b1, 1'b0, 4'd0, 4'd0},
    {1'b0, 1'b1, 1'b0, 4'd0, 4'd15},
    {1'b1, 1'b1, 1'b1, 4'd5, 4'd0},    // reset beats load and count
    {1'b0, 1'b0, 1'b1, 4'd1, 4'd1},
    {1'b0, 1'b1, 1'b0, 4'd0, 4'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive inputs now (negedge+2), return at the next negedge+2 with results settled.
  task automatic apply(input logic r, input logic c, input logic l, input logic [3:0] v);
    rst = r; cntEn = c; loadEn = l; loadVal = v;
    @(negedge clk);
    #2;
  endtask

  initial begin
    int e0;
    logic [3:0] refCount;
    @(negedge clk);
    #2;

    // Table walk: R1 R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
      check(count == VEC[i][3:0], $sformatf("R1/R2/R3/R4 vec%0d", i),
            count, VEC[i][3:0]);
    end

    // Reset state
    apply(1'b1, 1'b0, 1'b0, 4'd0);
    check(count == 4'd0, "R1 reset state", count, 0);

    // Three uninterrupted wraps against an ungated reference: R3 R5 R6 R8
    refCount = 4'd0;
    pureCount = 1'b1;
    e0 = upEdges;
    badEdges = 0;
    for (int k = 0; k < 48; k++) begin
      apply(1'b0, 1'b1, 1'b0, 4'd0);
      refCount = refCount - 4'd1;
      check(count == refCount, "R3 wrap count", count, refCount);
      check(upClkOut == 1'b0, "R8 gated clock low in low phase", upClkOut, 0);
    end
    pureCount = 1'b0;
    check(upEdges - e0 == 36, "R5 upper pulses over three wraps", upEdges - e0, 36);
    check(badEdges == 0, "R6 upper pulse leaving odd count below 8", badEdges, 0);

    // Directed: step from 3 gives no upper pulse (R6), still reaches 2
    apply(1'b0, 1'b0, 1'b1, 4'd3);
    e0 = upEdges;
    apply(1'b0, 1'b1, 1'b0, 4'd0);
    check(upEdges == e0, "R6 no pulse stepping from 3", upEdges - e0, 0);
    check(count == 4'd2, "R3 step 3 to 2", count, 2);

    // Step from 2 borrows into bit 1 (R5)
    e0 = upEdges;
    apply(1'b0, 1'b1, 1'b0, 4'd0);
    check(upEdges - e0 == 1, "R5 pulse on borrow from 2", upEdges - e0, 1);
    check(count == 4'd1, "R5 step 2 to 1", count, 1);

    // Load while at 1 forces the upper clock (R7)
    e0 = upEdges;
    apply(1'b0, 1'b0, 1'b1, 4'd5);
    check(upEdges - e0 == 1, "R7 load forces upper pulse at 1", upEdges - e0, 1);
    check(count == 4'd5, "R7 load value", count, 5);

    // Idle at 5: no upper pulse, value held (R6 R4)
    e0 = upEdges;
    apply(1'b0, 1'b0, 1'b0, 4'd12);
    apply(1'b0, 1'b0, 1'b0, 4'd12);
    check(upEdges == e0, "R6 idle gives no upper pulse", upEdges - e0, 0);
    check(count == 4'd5, "R4 idle holds 5", count, 5);

    // Reset at 5 forces the upper clock (R7)
    e0 = upEdges;
    apply(1'b1, 1'b0, 1'b0, 4'd0);
    check(upEdges - e0 == 1, "R7 reset forces upper pulse at 5", upEdges - e0, 1);
    check(count == 4'd0, "R1 reset from 5", count, 0);

    // Load of 15 then step: top bit set keeps upper clock on (R5)
    apply(1'b0, 1'b0, 1'b1, 4'd15);
    e0 = upEdges;
    apply(1'b0, 1'b1, 1'b0, 4'd0);
    check(upEdges - e0 == 1, "R5 pulse stepping from 15", upEdges - e0, 1);
    check(count == 4'd14, "R3 step 15 to 14", count, 14);

    apply(1'b0, 1'b0, 1'b0, 4'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule